// File: doc/BRIEF.md
# GHASH Multiply-Accumulate Engine with Sparse Reduction

The block hashes a stream of M-bit blocks over GF(2^M), with the field fixed as polynomials modulo f(x) = x^M + e(x), where e(x) has a low degree. A hash key H is loaded once. Each message then flows in as a run of blocks, one per clock when present. The first block seeds an accumulator. Every later block folds in as V <- H*V + C. After the block flagged as last, one more multiplication by H with no addition produces the tag.

Multiplication by H is a constant matrix applied to V. When the key is loaded, that matrix is split into two parts and both are held in registers. One part is a Toeplitz matrix, stored as its 2M-1 diagonal values. The other is a sparse remainder whose non-zero entries sit only in the lowest deg(e)+1 rows. The Toeplitz product and the few sparse row dot-products are evaluated side by side, and their results are XORed together. The low degree of e(x) is what keeps the sparse part small.

The block takes no part in encryption, bit reflection or length blocks. Polynomial coefficient i sits at vector bit i.

Top module: `ghash_engine`

## Requirements
- R1: While `rst` is high and after it falls, `tag_valid` is 0 and `tag_out` is all zeros until the first tag is produced.
- R2: Arithmetic is over GF(2)[x] modulo x^M + e(x). Bit i of `E_POLY` is the coefficient of x^i in e(x). Bit i of every data vector is the coefficient of x^i.
- R3: A block accepted while no message is open (idle, or the tag cycle of the previous message) is stored into the accumulator unchanged.
- R4: A block accepted while a message is open replaces the accumulator V with H*V xor C.
- R5: A cycle with `blk_valid` low leaves the accumulator unchanged and keeps an open message open.
- R6: One cycle after the block with `blk_last` is accepted, `tag_valid` is high for one cycle and `tag_out` carries H*V. `tag_out` keeps that value until the next tag.
- R7: A block presented in the tag cycle is accepted as the first block of the next message, in the same cycle that the tag is formed.
- R8: `key_load` stores the new key for all blocks accepted from the next cycle onward. It closes any open message, cancels a tag that is due in that cycle, and causes a block presented in the same cycle to be ignored.
- R9: A one-block message (`blk_valid` and `blk_last` together on its first block) yields the tag H*C.
- R10: Products whose unreduced degree is close to 2M-2 are fully reduced. For example, H = C = x^(M-1) gives the tag x^(M-2)*e(x) reduced modulo f(x).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Take `key_in` as the new hash key |
| key_in | input | M | Hash key H |
| blk_valid | input | 1 | A block is present on `blk_data` this cycle |
| blk_last | input | 1 | The present block ends its message |
| blk_data | input | M | Data block C_i |
| tag_valid | output | 1 | One-cycle strobe: `tag_out` holds a new tag |
| tag_out | output | M | Most recent tag |

## Verification
Two instances run side by side: one with M=16 and e(x)=x^5+x^3+x^2+1, the other with M=8 and e(x)=x^4+x^3+x+1. Both are compared every clock against a bit-serial shift-and-reduce model. The directed patterns are as follows:
- A unit block checks that the tag equals H, which exposes any mismatch in bit order.
- x^(M-1) times x^(M-1) checks that the second reduction pass is present.
- Multi-block messages with gaps separate the seed path from the multiply-accumulate path.
- Back-to-back messages show whether a block arriving in the tag cycle is lost or folded into the old message.
- Key loads during a message, in the tag cycle and alongside a block check the abort rules.

A long run with a random valid pattern, random last flags and random key changes then mixes all of these cases.

// File: rtl/ghash_pkg.sv
package ghash_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAG  = 2'd2
    } ghash_state_e;

    // Index of the highest set coefficient; sizes the sparse row count.
    function automatic int poly_degree(input logic [63:0] p);
        int d;
        d = 0;
        for (int i = 0; i < 64; i++) begin
            if (p[i]) d = i;
        end
        return d;
    endfunction

endpackage

// File: rtl/ghash_key_prep.sv
module ghash_key_prep #(
    parameter int          M      = 16,
    parameter logic [M-1:0] E_POLY = 16'h002D,
    parameter int          SROWS  = 6
) (
    input  logic [M-1:0]             key,
    output logic [2*M-2:0]           diag,
    output logic [SROWS-1:0][M-1:0]  srow
);
    localparam int DW = 2*M - 1;

    // Column j of the reduced multiply-by-H matrix is H*x^j mod f.
    logic [M-1:0] col [M];

    always_comb begin
        col[0] = key;
        for (int j = 1; j < M; j++) begin
            col[j] = {col[j-1][M-2:0], 1'b0} ^ (col[j-1][M-1] ? E_POLY : '0);
        end
    end

    // Rows SROWS..M-1 share diagonals; row SROWS covers the upper
    // diagonals and row M-1 the lower ones.
    always_comb begin
        for (int k = 0; k < DW; k++) begin
            if (k < SROWS) begin
                diag[k] = 1'b0;
            end else if (k <= SROWS + M - 1) begin
                diag[k] = col[SROWS + M - 1 - k][SROWS];
            end else begin
                diag[k] = col[2*M - 2 - k][M-1];
            end
        end
    end

    // Sparse remainder: what the Toeplitz part misses in the low rows.
    always_comb begin
        for (int i = 0; i < SROWS; i++) begin
            for (int j = 0; j < M; j++) begin
                srow[i][j] = col[j][i] ^ diag[i - j + M - 1];
            end
        end
    end

endmodule

// File: rtl/ghash_toeplitz_mul.sv
module ghash_toeplitz_mul #(
    parameter int M = 16
) (
    input  logic [2*M-2:0] diag,
    input  logic [M-1:0]   vec,
    output logic [M-1:0]   prod
);
    always_comb begin
        for (int i = 0; i < M; i++) begin
            prod[i] = 1'b0;
            for (int j = 0; j < M; j++) begin
                prod[i] = prod[i] ^ (diag[i - j + M - 1] & vec[j]);
            end
        end
    end
endmodule

// File: rtl/ghash_sparse_rows.sv
module ghash_sparse_rows #(
    parameter int M     = 16,
    parameter int SROWS = 6
) (
    input  logic [SROWS-1:0][M-1:0] srow,
    input  logic [M-1:0]            vec,
    output logic [M-1:0]            prod
);
    logic [SROWS-1:0] dot;

    // One AND plane plus XOR tree per non-Toeplitz row.
    for (genvar r = 0; r < SROWS; r++) begin : g_row
        assign dot[r] = ^(srow[r] & vec);
    end

    if (SROWS < M) begin : g_pad
        assign prod = {{(M-SROWS){1'b0}}, dot};
    end else begin : g_full
        assign prod = dot;
    end
endmodule

// File: rtl/ghash_engine.sv
module ghash_engine
    import ghash_pkg::*;
#(
    parameter int           M      = 16,
    parameter logic [M-1:0] E_POLY = 16'h002D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          key_load,
    input  logic [M-1:0]  key_in,
    input  logic          blk_valid,
    input  logic          blk_last,
    input  logic [M-1:0]  blk_data,
    output logic          tag_valid,
    output logic [M-1:0]  tag_out
);
    localparam int SROWS = poly_degree(64'(E_POLY)) + 1;
    localparam int DW    = 2*M - 1;

    logic [DW-1:0]             diag_d, diag_q;
    logic [SROWS-1:0][M-1:0]   srow_d, srow_q;
    logic [M-1:0]              acc_q, tpl_p, spr_p, mh_v, tag_q;
    logic                      tag_v_q;
    ghash_state_e              state_q;

    ghash_key_prep #(.M(M), .E_POLY(E_POLY), .SROWS(SROWS)) u_prep (
        .key  (key_in),
        .diag (diag_d),
        .srow (srow_d)
    );

    ghash_toeplitz_mul #(.M(M)) u_tpl (
        .diag (diag_q),
        .vec  (acc_q),
        .prod (tpl_p)
    );

    ghash_sparse_rows #(.M(M), .SROWS(SROWS)) u_spr (
        .srow (srow_q),
        .vec  (acc_q),
        .prod (spr_p)
    );

    assign mh_v = tpl_p ^ spr_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            diag_q  <= '0;
            srow_q  <= '0;
            acc_q   <= '0;
            tag_q   <= '0;
            tag_v_q <= 1'b0;
            state_q <= ST_IDLE;
        end else begin
            tag_v_q <= 1'b0;
            if (key_load) begin
                diag_q  <= diag_d;
                srow_q  <= srow_d;
                state_q <= ST_IDLE;
            end else begin
                if (state_q == ST_TAG) begin
                    tag_q   <= mh_v;
                    tag_v_q <= 1'b1;
                end
                if (blk_valid) begin
                    acc_q   <= (state_q == ST_RUN) ? (mh_v ^ blk_data) : blk_data;
                    state_q <= blk_last ? ST_TAG : ST_RUN;
                end else if (state_q == ST_TAG) begin
                    state_q <= ST_IDLE;
                end
            end
        end
    end

    assign tag_valid = tag_v_q;
    assign tag_out   = tag_q;

    AST_TAG_HOLD:  assert property (@(posedge clk) disable iff (rst)
        !tag_valid |-> $stable(tag_out)); // R6
    AST_TAG_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAG && !key_load) |=> tag_valid); // R6
    AST_KEY_CANCEL: assert property (@(posedge clk) disable iff (rst)
        key_load |=> !tag_valid); // R8
    AST_ACC_IDLE:  assert property (@(posedge clk) disable iff (rst)
        (!blk_valid || key_load) |=> $stable(acc_q)); // R5
    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN && blk_valid && !key_load) |=> acc_q == $past(blk_data)); // R3
    AST_STATE_OK:  assert property (@(posedge clk) disable iff (rst)
        state_q != 2'd3); // R7

endmodule

// File: tb/ghash_engine_test.sv
`timescale 1ns/1ps
module ghash_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_load = 1'b0;
    logic [15:0] key_in = '0;
    logic        blk_valid = 1'b0;
    logic        blk_last = 1'b0;
    logic [15:0] blk_data = '0;

    logic        tv16, tv8;
    logic [15:0] tag16;
    logic [7:0]  tag8;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    always #2.5 clk = ~clk;

    // The narrow instance sees the two bytes folded together.
    ghash_engine #(.M(16), .E_POLY(16'h002D)) uut (
        .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
        .blk_valid(blk_valid), .blk_last(blk_last), .blk_data(blk_data),
        .tag_valid(tv16), .tag_out(tag16)
    );

    ghash_engine #(.M(8), .E_POLY(8'h1B)) uut8 (
        .clk(clk), .rst(rst), .key_load(key_load),
        .key_in(key_in[15:8] ^ key_in[7:0]),
        .blk_valid(blk_valid), .blk_last(blk_last),
        .blk_data(blk_data[15:8] ^ blk_data[7:0]),
        .tag_valid(tv8), .tag_out(tag8)
    );

    // Bit-serial shift-and-reduce product in GF(2^w).
    function automatic logic [15:0] gmul(input logic [15:0] a, input logic [15:0] b,
                                         input int w, input logic [15:0] e);
        logic [15:0] r, mask;
        logic        msb;
        r    = '0;
        mask = 16'((32'd1 << w) - 1);
        for (int i = w - 1; i >= 0; i--) begin
            msb = r[w-1];
            r   = (r << 1) & mask;
            if (msb) r = r ^ e;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    // Model state: index 0 is the 8-bit instance, 1 the 16-bit one.
    logic [15:0] m_key [2];
    logic [15:0] m_acc [2];
    logic [15:0] m_tag [2];
    logic        m_tv  [2];
    int          m_st  [2];

    always @(posedge clk) begin
        for (int u = 0; u < 2; u++) begin
            int          w;
            logic [15:0] e, k, d;
            w = u ? 16 : 8;
            e = u ? 16'h002D : 16'h001B;
            k = u ? key_in : {8'h00, key_in[15:8] ^ key_in[7:0]};
            d = u ? blk_data : {8'h00, blk_data[15:8] ^ blk_data[7:0]};
            if (rst) begin
                m_key[u] = '0; m_acc[u] = '0; m_tag[u] = '0;
                m_tv[u] = 1'b0; m_st[u] = 0;
            end else begin
                m_tv[u] = 1'b0;
                if (key_load) begin
                    m_key[u] = k;
                    m_st[u]  = 0;
                end else begin
                    if (m_st[u] == 2) begin
                        m_tag[u] = gmul(m_acc[u], m_key[u], w, e);
                        m_tv[u]  = 1'b1;
                    end
                    if (blk_valid) begin
                        if (m_st[u] == 1) m_acc[u] = gmul(m_acc[u], m_key[u], w, e) ^ d;
                        else              m_acc[u] = d;
                        m_st[u] = blk_last ? 2 : 1;
                    end else if (m_st[u] == 2) begin
                        m_st[u] = 0;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        for (int u = 0; u < 2; u++) begin
            logic        otv;
            logic [15:0] otag;
            otv  = u ? tv16 : tv8;
            otag = u ? tag16 : {8'h00, tag8};
            n_checks++;
            if (otv !== m_tv[u]) begin
                n_fail++;
                $display("FAIL %s tag_valid M=%0d actual=%b expected=%b", cur_req,
                         u ? 16 : 8, otv, m_tv[u]);
            end
            n_checks++;
            if (otag !== m_tag[u]) begin
                n_fail++;
                $display("FAIL %s tag_out M=%0d actual=%h expected=%h", cur_req,
                         u ? 16 : 8, otag, m_tag[u]);
            end
        end
    end

    task automatic drive(input logic kl, input logic [15:0] k, input logic v,
                         input logic l, input logic [15:0] d);
        @(negedge clk);
        #1;
        key_load = kl; key_in = k; blk_valid = v; blk_last = l; blk_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, key_in, 1'b0, 1'b0, '0);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        idle(3);

        cur_req = "R8";
        drive(1'b1, 16'h1234, 1'b0, 1'b0, '0);
        idle(1);

        cur_req = "R9";
        drive(1'b0, 16'h0, 1'b1, 1'b1, 16'h0001);
        idle(3);
        drive(1'b0, 16'h0, 1'b1, 1'b1, 16'hBEEF);
        idle(3);

        cur_req = "R10";
        drive(1'b1, 16'h8000, 1'b0, 1'b0, '0);
        drive(1'b0, 16'h8000, 1'b1, 1'b1, 16'h8000);
        idle(3);

        cur_req = "R2";
        drive(1'b1, 16'h0002, 1'b0, 1'b0, '0);
        drive(1'b0, 16'h0002, 1'b1, 1'b1, 16'hC3A5);
        idle(3);

        cur_req = "R4";
        drive(1'b1, 16'hA5F0, 1'b0, 1'b0, '0);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b0, 16'h1111);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b0, 16'h2222);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b1, 16'hFFFF);
        idle(3);

        cur_req = "R5";
        drive(1'b0, 16'hA5F0, 1'b1, 1'b0, 16'h0F0F);
        idle(4);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b0, 16'h7777);
        idle(2);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b1, 16'h0001);
        idle(3);

        cur_req = "R7";
        drive(1'b0, 16'hA5F0, 1'b1, 1'b1, 16'h1357);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b0, 16'h2468);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b1, 16'h9999);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b1, 16'h4321);
        idle(3);

        cur_req = "R3";
        drive(1'b0, 16'hA5F0, 1'b1, 1'b0, 16'hDEAD);
        drive(1'b0, 16'hA5F0, 1'b1, 1'b1, 16'h0000);
        idle(3);

        cur_req = "R8";
        drive(1'b0, 16'hA5F0, 1'b1, 1'b0, 16'h5555);
        drive(1'b1, 16'h0F1E, 1'b0, 1'b0, '0);
        drive(1'b0, 16'h0F1E, 1'b1, 1'b1, 16'h00FF);
        idle(3);
        drive(1'b0, 16'h0F1E, 1'b1, 1'b1, 16'h3C3C);
        drive(1'b1, 16'h7001, 1'b1, 1'b1, 16'hAAAA);
        idle(3);
        drive(1'b0, 16'h7001, 1'b1, 1'b1, 16'h0101);
        idle(3);

        cur_req = "R6";
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] r;
            r = $urandom;
            drive((r[7:0] == 8'h00), 16'($urandom), r[8] | r[9],
                  (r[12:10] == 3'b000), 16'($urandom));
        end
        idle(4);
        finish_run();
    end

endmodule